// File: doc/BRIEF.md
# ATA Device Task-File and Status Engine

This block is the device end of a parallel ATA register interface. The host reaches eight byte-wide registers through a 3-bit offset. Offset 7 reads back the status byte and takes command opcodes when written. A separate 16-bit data port carries the words of a PIO-in transfer. The block latches the addressing registers, decodes the opcode written to offset 7, sequences the BSY/DRDY/DRQ/ERR status bits and drives a level interrupt request. The host clears that request by reading status.

Three commands are implemented. IDENTIFY exposes a computed 256-word parameter block through the data port. FLUSH CACHE stays busy until an external completion strobe arrives. A stand-in for sector reads moves no data; it stays busy for a fixed number of cycles and then completes, so that the busy-to-ready path can be tested. Any other opcode, and any command aimed at device 1, is rejected with an error. Media storage, DMA and packet commands are not part of the block.

Top module: `ata_taskfile_dev`

## Requirements
- R1: Bytes written at offsets 1 to 6 (feature, sector count, LBA bits 7:0, 15:8, 23:16, device) read back unchanged at the same offsets. A byte read at offset 0 returns 0x00.
- R2: After reset, status (offset 7) reads 0x40, `intrq` is low and `data_rdata` is 0x0000. Status bits are BSY 0x80, DRDY 0x40, DF 0x20, DRQ 0x08 and ERR 0x01.
- R3: In the device register, bit 6 requests LBA addressing and bit 4 selects device 1. A command written while bit 4 is set is rejected: status 0x41 and `intrq` high.
- R4: Opcode 0xEC starts a 256-word transfer. Status reads 0x48 and `intrq` is high before the first word. Status stays 0x48 before every word read.
- R5: After the 256th data-port read, status reads 0x40.
- R6: IDENTIFY word i equals {0x5A XOR i, i}. There are two exceptions: word 0 is 0x0040, and word 85 has bit 5 forced to 1, giving 0x0F75.
- R7: Opcode 0xE7 holds status at 0xC0 until `flush_done` is sampled high. On the clock edge that samples it, status becomes 0x40 and `intrq` rises.
- R8: A read of offset 7 clears `intrq` on that clock edge.
- R9: Opcode 0x20 holds status at 0xC0 for exactly STUB_CYCLES cycles. Status then reads 0x40 and `intrq` is high.
- R10: A command written while BSY is set has no effect on state, status or the interrupt.
- R11: Any other opcode gives status 0x41 and raises `intrq`. The next accepted command clears ERR.
- R12: A data-port read while DRQ is clear returns 0x0000 and changes neither status nor the IDENTIFY word position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register byte write strobe |
| reg_rd | input | 1 | Register byte read strobe (side effects only) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Read byte for `reg_addr` (combinational) |
| data_rd | input | 1 | Data-port word read strobe |
| data_rdata | output | 16 | Current data-port word (combinational) |
| flush_done | input | 1 | Cache flush completion |
| intrq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check several properties. BSY and DRQ are never set together. A status read in the idle state leaves the interrupt low. The last IDENTIFY word returns the engine to idle. A pending flush holds busy, and no command can dislodge it. The read stand-in completes with the interrupt raised. The data port stays at zero without DRQ. Some behaviours can only be shown by the bench's scenarios: the exact content of all 256 parameter words, register readback, the exact number of busy cycles, clearing of ERR by a later command, and the fact that a stray data-port read does not advance the word position.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

    // status byte bit positions
    localparam int unsigned ST_BSY  = 7;
    localparam int unsigned ST_DRDY = 6;
    localparam int unsigned ST_DF   = 5;
    localparam int unsigned ST_DRQ  = 3;
    localparam int unsigned ST_ERR  = 0;

    // device register fields
    localparam int unsigned DEVREG_SEL = 4;
    localparam int unsigned DEVREG_LBA = 6;

    // register offsets
    localparam logic [2:0] OFS_DATA   = 3'd0;
    localparam logic [2:0] OFS_FEAT   = 3'd1;
    localparam logic [2:0] OFS_COUNT  = 3'd2;
    localparam logic [2:0] OFS_ADDR0  = 3'd3;
    localparam logic [2:0] OFS_ADDR1  = 3'd4;
    localparam logic [2:0] OFS_ADDR2  = 3'd5;
    localparam logic [2:0] OFS_DEVSEL = 3'd6;
    localparam logic [2:0] OFS_STACMD = 3'd7;

    // opcodes handled
    localparam logic [7:0] OP_IDENT = 8'hEC;
    localparam logic [7:0] OP_FLUSH = 8'hE7;
    localparam logic [7:0] OP_RDSTUB = 8'h20;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_XFER  = 2'd1,
        ENG_FLUSH = 2'd2,
        ENG_STUB  = 2'd3
    } eng_state_e;

    typedef struct packed {
        logic [7:0] feat;
        logic [7:0] count;
        logic [7:0] addr0;
        logic [7:0] addr1;
        logic [7:0] addr2;
        logic [7:0] devsel;
    } tf_shadow_t;

endpackage

// File: rtl/ata_id_rom.sv
module ata_id_rom #(
    parameter int unsigned ID_WORDS = 256,
    localparam int unsigned IDX_W   = $clog2(ID_WORDS)
) (
    input  logic [IDX_W-1:0] idx,
    output logic [15:0]      word
);
    // parameter block is computed rather than stored
    localparam int unsigned CACHE_WORD = 85;
    localparam int unsigned CACHE_BIT  = 5;

    logic [7:0] low_b;

    always_comb begin
        low_b = 8'(idx);
        word  = {low_b ^ 8'h5A, low_b};
        if (idx == IDX_W'(0)) begin
            word = 16'h0040;
        end
        if (idx == IDX_W'(CACHE_WORD)) begin
            word[CACHE_BIT] = 1'b1;
        end
    end

    initial begin
        AST_ROM_DEPTH: assert (ID_WORDS > CACHE_WORD) else $error("parameter block too short"); // R6
    end
endmodule

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
    import ata_tf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rd_byte,
    output logic       dev1_sel
);
    typedef struct packed {
        tf_shadow_t sh;
    } regs_st_t;

    regs_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (addr)
                OFS_FEAT:   st_d.sh.feat   = wdata;
                OFS_COUNT:  st_d.sh.count  = wdata;
                OFS_ADDR0:  st_d.sh.addr0  = wdata;
                OFS_ADDR1:  st_d.sh.addr1  = wdata;
                OFS_ADDR2:  st_d.sh.addr2  = wdata;
                OFS_DEVSEL: st_d.sh.devsel = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (addr)
            OFS_FEAT:   rd_byte = st_q.sh.feat;
            OFS_COUNT:  rd_byte = st_q.sh.count;
            OFS_ADDR0:  rd_byte = st_q.sh.addr0;
            OFS_ADDR1:  rd_byte = st_q.sh.addr1;
            OFS_ADDR2:  rd_byte = st_q.sh.addr2;
            OFS_DEVSEL: rd_byte = st_q.sh.devsel;
            default:    rd_byte = 8'h00;
        endcase
    end

    assign dev1_sel = st_q.sh.devsel[DEVREG_SEL];

    AST_REG_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_COUNT) |=> (st_q.sh.count == $past(wdata))); // R1
endmodule

// File: rtl/ata_cmd_engine.sv
module ata_cmd_engine
    import ata_tf_pkg::*;
#(
    parameter int unsigned ID_WORDS    = 256,
    parameter int unsigned STUB_CYCLES = 4,
    localparam int unsigned IDX_W      = $clog2(ID_WORDS),
    localparam int unsigned SCNT_W     = $clog2(STUB_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [7:0]       opcode,
    input  logic             dev1_sel,
    input  logic             status_rd,
    input  logic             word_rd,
    input  logic             flush_done,
    output logic [7:0]       status,
    output logic             drq,
    output logic [IDX_W-1:0] word_idx,
    output logic             intrq
);
    typedef struct packed {
        eng_state_e        state;
        logic [IDX_W-1:0]  wcnt;
        logic [SCNT_W-1:0] scnt;
        logic              err;
        logic              irq;
    } eng_st_t;

    eng_st_t st_d, st_q;
    logic    busy;

    assign busy = (st_q.state == ENG_FLUSH) || (st_q.state == ENG_STUB);

    always_comb begin
        st_d = st_q;
        if (status_rd) st_d.irq = 1'b0;

        unique case (st_q.state)
            ENG_XFER: begin
                if (word_rd) begin
                    if (st_q.wcnt == IDX_W'(ID_WORDS - 1)) begin
                        st_d.state = ENG_IDLE;
                        st_d.wcnt  = '0;
                    end else begin
                        st_d.wcnt = st_q.wcnt + 1'b1;
                    end
                end
            end
            ENG_FLUSH: begin
                if (flush_done) begin
                    st_d.state = ENG_IDLE;
                    st_d.irq   = 1'b1;
                end
            end
            ENG_STUB: begin
                if (st_q.scnt == SCNT_W'(STUB_CYCLES - 1)) begin
                    st_d.state = ENG_IDLE;
                    st_d.scnt  = '0;
                    st_d.irq   = 1'b1;
                end else begin
                    st_d.scnt = st_q.scnt + 1'b1;
                end
            end
            default: ;
        endcase

        // command acceptance overrides the ongoing sequence unless busy
        if (cmd_wr && !busy) begin
            st_d.err  = 1'b0;
            st_d.irq  = 1'b0;
            st_d.wcnt = '0;
            st_d.scnt = '0;
            if (dev1_sel) begin
                st_d.state = ENG_IDLE;
                st_d.err   = 1'b1;
                st_d.irq   = 1'b1;
            end else begin
                unique case (opcode)
                    OP_IDENT: begin
                        st_d.state = ENG_XFER;
                        st_d.irq   = 1'b1;
                    end
                    OP_FLUSH:  st_d.state = ENG_FLUSH;
                    OP_RDSTUB: st_d.state = ENG_STUB;
                    default: begin
                        st_d.state = ENG_IDLE;
                        st_d.err   = 1'b1;
                        st_d.irq   = 1'b1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: ENG_IDLE, wcnt: '0, scnt: '0, err: 1'b0, irq: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status          = 8'h00;
        status[ST_BSY]  = busy;
        status[ST_DRDY] = 1'b1;
        status[ST_DF]   = 1'b0;
        status[ST_DRQ]  = (st_q.state == ENG_XFER);
        status[ST_ERR]  = st_q.err;
    end

    assign drq      = (st_q.state == ENG_XFER);
    assign word_idx = st_q.wcnt;
    assign intrq    = st_q.irq;

    AST_BSY_DRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[ST_BSY] && status[ST_DRQ])); // R4

    AST_IRQ_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && st_q.state == ENG_IDLE && !cmd_wr) |=> !intrq); // R8

    AST_LAST_WORD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ENG_XFER && word_rd && !cmd_wr && st_q.wcnt == IDX_W'(ID_WORDS - 1))
        |=> (st_q.state == ENG_IDLE && !status[ST_DRQ])); // R5

    AST_FLUSH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ENG_FLUSH && !flush_done) |=> (st_q.state == ENG_FLUSH && status[ST_BSY])); // R7

    AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr && st_q.state == ENG_FLUSH && !flush_done) |=> $stable(st_q.err)); // R10

    AST_STUB_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ENG_STUB && st_q.scnt == SCNT_W'(STUB_CYCLES - 1))
        |=> (st_q.state == ENG_IDLE && intrq)); // R9
endmodule

// File: rtl/ata_taskfile_dev.sv
module ata_taskfile_dev
    import ata_tf_pkg::*;
#(
    parameter int unsigned ID_WORDS    = 256,
    parameter int unsigned STUB_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        data_rd,
    output logic [15:0] data_rdata,
    input  logic        flush_done,
    output logic        intrq
);
    localparam int unsigned IDX_W = $clog2(ID_WORDS);

    logic [7:0]       shadow_byte;
    logic [7:0]       status;
    logic             dev1_sel;
    logic             drq;
    logic [IDX_W-1:0] word_idx;
    logic [15:0]      rom_word;
    logic             cmd_wr;
    logic             status_rd;

    assign cmd_wr    = reg_wr && (reg_addr == OFS_STACMD);
    assign status_rd = reg_rd && (reg_addr == OFS_STACMD);

    ata_tf_regs i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rd_byte  (shadow_byte),
        .dev1_sel (dev1_sel)
    );

    ata_cmd_engine #(
        .ID_WORDS    (ID_WORDS),
        .STUB_CYCLES (STUB_CYCLES)
    ) i_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .opcode     (reg_wdata),
        .dev1_sel   (dev1_sel),
        .status_rd  (status_rd),
        .word_rd    (data_rd),
        .flush_done (flush_done),
        .status     (status),
        .drq        (drq),
        .word_idx   (word_idx),
        .intrq      (intrq)
    );

    ata_id_rom #(
        .ID_WORDS (ID_WORDS)
    ) i_rom (
        .idx  (word_idx),
        .word (rom_word)
    );

    assign reg_rdata  = (reg_addr == OFS_STACMD) ? status : shadow_byte;
    assign data_rdata = drq ? rom_word : 16'h0000;

    AST_DATA_ZERO_NO_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !status[ST_DRQ] |-> (data_rdata == 16'h0000)); // R12
endmodule

// File: tb/test_ata_taskfile_dev.sv
module test_ata_taskfile_dev;
    localparam int STUB_CYCLES = 4;
    localparam int ID_WORDS    = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        data_rd = 1'b0;
    logic [15:0] data_rdata;
    logic        flush_done = 1'b0;
    logic        intrq;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ata_taskfile_dev #(.ID_WORDS(ID_WORDS), .STUB_CYCLES(STUB_CYCLES)) i_ata_taskfile_dev (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .data_rd(data_rd), .data_rdata(data_rdata), .flush_done(flush_done),
        .intrq(intrq)
    );

    // {offset, byte written, byte expected back}
    localparam logic [18:0] VEC [8] = '{
        {3'd1, 8'h11, 8'h11},
        {3'd2, 8'h01, 8'h01},
        {3'd3, 8'h34, 8'h34},
        {3'd4, 8'h12, 8'h12},
        {3'd5, 8'hA9, 8'hA9},
        {3'd6, 8'h50, 8'h50},
        {3'd6, 8'hE0, 8'hE0},
        {3'd6, 8'h40, 8'h40}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_word(output logic [15:0] w);
        @(negedge clk);
        w = data_rdata; data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
    endtask

    // peek at status without a read strobe
    task automatic peek_status(output logic [7:0] s);
        reg_addr = 3'd7;
        #1 s = reg_rdata;
    endtask

    function automatic logic [15:0] id_exp(input int i);
        logic [15:0] w;
        w = {8'(i) ^ 8'h5A, 8'(i)};
        if (i == 0) w = 16'h0040;
        if (i == 85) w = w | 16'h0020;
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] w;
        int          cnt;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        peek_status(b);
        check("R2 status", {8'h0, b}, 16'h0040);
        check("R2 intrq", {15'h0, intrq}, 16'h0000);
        check("R2 data", data_rdata, 16'h0000);

        // R1 table walk
        for (int k = 0; k < 8; k++) begin
            wr(VEC[k][18:16], VEC[k][15:8]);
            rd(VEC[k][18:16], b);
            check("R1 readback", {8'h0, b}, {8'h0, VEC[k][7:0]});
        end
        rd(3'd0, b);
        check("R1 offset0", {8'h0, b}, 16'h0000);

        // R12 stray data read
        rd_word(w);
        check("R12 data zero", w, 16'h0000);
        peek_status(b);
        check("R12 status unchanged", {8'h0, b}, 16'h0040);

        // R4/R5/R6 identify
        wr(3'd7, 8'hEC);
        check("R4 intrq", {15'h0, intrq}, 16'h0001);
        for (int i = 0; i < ID_WORDS; i++) begin
            rd(3'd7, b);
            check("R4 status per word", {8'h0, b}, 16'h0048);
            rd_word(w);
            check("R6 word", w, id_exp(i));
        end
        check("R8 intrq cleared", {15'h0, intrq}, 16'h0000);
        peek_status(b);
        check("R5 after last", {8'h0, b}, 16'h0040);
        check("R6 word85 bit5", {15'h0, id_exp(85)[5]}, 16'h0001);

        // R11 unknown opcode
        wr(3'd7, 8'h91);
        peek_status(b);
        check("R11 err status", {8'h0, b}, 16'h0041);
        check("R11 intrq", {15'h0, intrq}, 16'h0001);
        rd(3'd7, b);
        check("R8 clear", {15'h0, intrq}, 16'h0000);

        // R9 stub, also clears ERR (R11)
        wr(3'd7, 8'h20);
        peek_status(b);
        check("R11 err cleared", {8'h0, b}, 16'h00C0);
        cnt = 0;
        while (cnt < 20) begin
            peek_status(b);
            if (!b[7]) break;
            cnt++;
            @(negedge clk);
        end
        check("R9 busy cycles", 16'(cnt), 16'(STUB_CYCLES));
        check("R9 done status", {8'h0, b}, 16'h0040);
        check("R9 intrq", {15'h0, intrq}, 16'h0001);
        rd(3'd7, b);

        // R7 flush with R10 command while busy
        wr(3'd7, 8'hE7);
        repeat (5) @(negedge clk);
        peek_status(b);
        check("R7 busy", {8'h0, b}, 16'h00C0);
        check("R7 no intrq yet", {15'h0, intrq}, 16'h0000);
        wr(3'd7, 8'hEC);
        peek_status(b);
        check("R10 ignored status", {8'h0, b}, 16'h00C0);
        check("R10 ignored intrq", {15'h0, intrq}, 16'h0000);
        @(negedge clk);
        flush_done = 1'b1;
        @(negedge clk);
        flush_done = 1'b0;
        peek_status(b);
        check("R7 done status", {8'h0, b}, 16'h0040);
        check("R7 intrq", {15'h0, intrq}, 16'h0001);
        check("R10 no transfer", data_rdata, 16'h0000);
        rd(3'd7, b);

        // R3 device 1 rejected
        wr(3'd6, 8'h50);
        wr(3'd7, 8'hEC);
        peek_status(b);
        check("R3 dev1 status", {8'h0, b}, 16'h0041);
        check("R3 dev1 intrq", {15'h0, intrq}, 16'h0001);
        check("R3 dev1 no data", data_rdata, 16'h0000);
        wr(3'd6, 8'h40);

        // R12 identify restarts at word 0 after a stray read
        rd_word(w);
        wr(3'd7, 8'hEC);
        rd_word(w);
        check("R12 first word", w, 16'h0040);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule